// File: doc/BRIEF.md
# Operand-Free Shelving Buffer with Issue-Time Register Read

This block sits in front of a single execution unit. It holds instructions that have been handed over by the decoder but have not yet started execution. Each slot stores only four fields: an opcode, a destination register number and two source register numbers. No operand values are kept in a slot.

The block also owns the register file. Each register has a ready flag next to it. When an instruction is dispatched, the ready flag of its destination is cleared. A slot becomes eligible once the flags of both of its sources are set. The register values are read only when the slot is selected for issue, and they leave the block together with the opcode and the destination number. A result returning from the execution unit writes its register and sets that register's flag again. Renaming and speculation are not part of this block. Upstream logic must not dispatch an instruction whose source names its own destination, and must keep write-after-read and write-after-write order on the same register.

Top module: `issue_shelf`

## Requirements
- R1: After reset the buffer is empty, `iss_valid` is 0, `disp_ready` is 1, and every register reads as 0 with its ready flag set.
- R2: A dispatch is accepted whenever `disp_ready` is 1, whatever the state of its source registers. No dependency check takes place at dispatch.
- R3: An accepted dispatch clears the ready flag of its destination register. A later instruction that reads that register is then held in the buffer.
- R4: A slot is offered on the issue port only while the ready flags of both its sources are set. `iss_a` carries the value of the first source register and `iss_b` the value of the second, both read from the register file in the issuing cycle. `iss_op` and `iss_rd` carry the slot's opcode and destination.
- R5: A result presented on the write port in cycle N stores the value and sets the register's flag. A slot waiting on that register is offered in cycle N+1 and carries the new value.
- R6: Among the eligible slots, the one dispatched earliest is offered, even if older slots are still blocked. At most one slot is offered per cycle. The offered slot leaves the buffer at the next clock edge.
- R7: With 4 slots occupied, `disp_ready` is 0 and a dispatch request is ignored.
- R8: If a dispatch and a result name the same register in the same cycle, the value is written but the ready flag stays cleared.
- R9: `disp_ready` depends only on the occupancy before the clock edge. A full buffer stalls dispatch even in a cycle in which it issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | Buffer can accept a dispatch |
| disp_op | input | 3 | Opcode of the dispatched instruction |
| disp_rd | input | 5 | Destination register number |
| disp_rs1 | input | 5 | First source register number |
| disp_rs2 | input | 5 | Second source register number |
| wb_valid | input | 1 | Result write enable |
| wb_rd | input | 5 | Register written by the result |
| wb_data | input | 32 | Result value |
| iss_valid | output | 1 | A slot is issued this cycle |
| iss_op | output | 3 | Opcode of the issued slot |
| iss_rd | output | 5 | Destination of the issued slot |
| iss_a | output | 32 | Value of the first source register |
| iss_b | output | 32 | Value of the second source register |

## Verification
The hardest state to reach from the ports is a younger slot being issued past an older one that is still blocked. A second hard case is a result that frees an older slot in the same cycle as a younger slot is issued. To reach these, the stimulus table dispatches a consumer of an unwritten register, then an independent instruction behind it. It returns the missing result only after the younger instruction has left. A directed test fills all four slots behind one missing register and releases them with one write. In that test the full-and-issuing cycle exercises the stall, and a dispatch request made while full must leave no trace when the buffer drains.

// File: rtl/issue_shelf.sv
module issue_shelf #(
  parameter int DEPTH = 4,
  parameter int NREG  = 32,
  parameter int XLEN  = 32,
  parameter int OPW   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     disp_valid,
  output logic                     disp_ready,
  input  logic [OPW-1:0]           disp_op,
  input  logic [$clog2(NREG)-1:0]  disp_rd,
  input  logic [$clog2(NREG)-1:0]  disp_rs1,
  input  logic [$clog2(NREG)-1:0]  disp_rs2,
  input  logic                     wb_valid,
  input  logic [$clog2(NREG)-1:0]  wb_rd,
  input  logic [XLEN-1:0]          wb_data,
  output logic                     iss_valid,
  output logic [OPW-1:0]           iss_op,
  output logic [$clog2(NREG)-1:0]  iss_rd,
  output logic [XLEN-1:0]          iss_a,
  output logic [XLEN-1:0]          iss_b
);
  localparam int RW = $clog2(NREG);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [OPW-1:0]  e_op [DEPTH];
  logic [RW-1:0]   e_rd [DEPTH];
  logic [RW-1:0]   e_s1 [DEPTH];
  logic [RW-1:0]   e_s2 [DEPTH];
  logic [CW-1:0]   count;
  logic [XLEN-1:0] rf [NREG];
  logic [NREG-1:0] rv;
  logic [DEPTH-1:0] rdy;
  logic [AW-1:0]   sel;
  logic [CW-1:0]   wpos;
  logic            fire;

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      rdy[i] = (CW'(i) < count) && rv[e_s1[i]] && rv[e_s2[i]];
    sel = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (rdy[i]) sel = AW'(i);
  end

  assign iss_valid  = |rdy;
  assign iss_op     = e_op[sel];
  assign iss_rd     = e_rd[sel];
  assign iss_a      = rf[e_s1[sel]];
  assign iss_b      = rf[e_s2[sel]];
  assign disp_ready = count < CW'(DEPTH);
  assign fire       = disp_valid && disp_ready;
  assign wpos       = count - CW'(iss_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      rv    <= '1;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        e_op[i] <= '0; e_rd[i] <= '0; e_s1[i] <= '0; e_s2[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH - 1; i++)
        if (iss_valid && AW'(i) >= sel) begin
          e_op[i] <= e_op[i+1]; e_rd[i] <= e_rd[i+1];
          e_s1[i] <= e_s1[i+1]; e_s2[i] <= e_s2[i+1];
        end
      if (fire) begin
        e_op[wpos[AW-1:0]] <= disp_op;
        e_rd[wpos[AW-1:0]] <= disp_rd;
        e_s1[wpos[AW-1:0]] <= disp_rs1;
        e_s2[wpos[AW-1:0]] <= disp_rs2;
      end
      count <= count + CW'(fire) - CW'(iss_valid);
      if (wb_valid) begin
        rf[wb_rd] <= wb_data;
        rv[wb_rd] <= 1'b1;
      end
      if (fire) rv[disp_rd] <= 1'b0;
    end
  end

  assert_full_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH)) |-> !disp_ready);
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_disp_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !rv[$past(disp_rd)]);
  assert_wb_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !(fire && disp_rd == wb_rd)) |=> rv[$past(wb_rd)]);
  assert_wb_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> rf[$past(wb_rd)] == $past(wb_data));
  assert_issue_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (count != '0));
  assert_one_leaves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !fire) |=> count == $past(count) - 1'b1);
endmodule

// File: tb/issue_shelf_tb_top.sv
module issue_shelf_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        disp_valid, disp_ready, wb_valid, iss_valid;
  logic [2:0]  disp_op, iss_op;
  logic [4:0]  disp_rd, disp_rs1, disp_rs2, wb_rd, iss_rd;
  logic [31:0] wb_data, iss_a, iss_b;

  issue_shelf dut_i (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_op(disp_op), .disp_rd(disp_rd), .disp_rs1(disp_rs1), .disp_rs2(disp_rs2),
    .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_data(wb_data),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_rd(iss_rd), .iss_a(iss_a), .iss_b(iss_b));

  typedef struct packed {
    logic dv; logic [2:0] op; logic [4:0] rd, s1, s2;
    logic wv; logic [4:0] wrd; logic [31:0] wd;
    logic ev; logic [2:0] eop; logic [4:0] erd; logic [31:0] ea, eb; logic erdy;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1,1,3,1,2, 0,0,0,          0,0,0,0,0,1},
    '{1,2,4,3,1, 1,1,32'h11,     1,1,3,0,0,1},
    '{0,0,0,0,0, 1,3,32'h33,     0,0,0,0,0,1},
    '{1,3,5,4,0, 0,0,0,          1,2,4,32'h33,32'h11,1},
    '{1,4,6,1,2, 0,0,0,          0,0,0,0,0,1},
    '{1,5,7,6,0, 1,4,32'h44,     1,4,6,32'h11,0,1},
    '{0,0,0,0,0, 1,6,32'h66,     1,3,5,32'h44,0,1},
    '{0,0,0,0,0, 0,0,0,          1,5,7,32'h66,0,1},
    '{1,6,8,9,9, 1,8,32'h88,     0,0,0,0,0,1},
    '{1,7,10,8,8, 0,0,0,         1,6,8,0,0,1},
    '{0,0,0,0,0, 0,0,0,          0,0,0,0,0,1},
    '{0,0,0,0,0, 1,8,32'h8a,     0,0,0,0,0,1},
    '{0,0,0,0,0, 0,0,0,          1,7,10,32'h8a,32'h8a,1}
  };

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle();
    disp_valid = 0; disp_op = 0; disp_rd = 0; disp_rs1 = 0; disp_rs2 = 0;
    wb_valid = 0; wb_rd = 0; wb_data = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle();
    repeat (2) @(negedge clk);
    chk("R1 iss_valid in reset", 32'(iss_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 disp_ready after reset", 32'(disp_ready), 1);

    // table walk: R2 R3 R4 R5 R6 R8
    for (int k = 0; k < NV; k++) begin
      disp_valid = VECS[k].dv; disp_op = VECS[k].op; disp_rd = VECS[k].rd;
      disp_rs1 = VECS[k].s1; disp_rs2 = VECS[k].s2;
      wb_valid = VECS[k].wv; wb_rd = VECS[k].wrd; wb_data = VECS[k].wd;
      #1;
      chk($sformatf("R4/R5/R6/R8 v%0d iss_valid", k), 32'(iss_valid), 32'(VECS[k].ev));
      chk($sformatf("R2 v%0d disp_ready", k), 32'(disp_ready), 32'(VECS[k].erdy));
      if (VECS[k].ev) begin
        chk($sformatf("R4 v%0d iss_op", k), 32'(iss_op), 32'(VECS[k].eop));
        chk($sformatf("R6 v%0d iss_rd", k), 32'(iss_rd), 32'(VECS[k].erd));
        chk($sformatf("R5 v%0d iss_a", k), iss_a, VECS[k].ea);
        chk($sformatf("R4 v%0d iss_b", k), iss_b, VECS[k].eb);
      end
      @(negedge clk);
    end
    idle();

    // directed: fill behind r5 (not ready), R7 full stall, R9, R6 order
    for (int k = 0; k < 4; k++) begin
      disp_valid = 1; disp_op = 3'(k + 1); disp_rd = 5'(11 + k); disp_rs1 = 5; disp_rs2 = 5;
      #1;
      chk("R2 accept dependent", 32'(disp_ready), 1);
      @(negedge clk);
    end
    disp_valid = 1; disp_op = 7; disp_rd = 15; disp_rs1 = 0; disp_rs2 = 0;
    #1;
    chk("R7 full disp_ready", 32'(disp_ready), 0);
    chk("R7 all blocked", 32'(iss_valid), 0);
    @(negedge clk);
    disp_valid = 0;
    wb_valid = 1; wb_rd = 5; wb_data = 32'h55;
    #1;
    chk("R7 ignored dispatch not issued", 32'(iss_valid), 0);
    @(negedge clk);
    idle();
    disp_valid = 1; disp_op = 7; disp_rd = 15; disp_rs1 = 0; disp_rs2 = 0;
    #1;
    chk("R9 full while issuing", 32'(disp_ready), 0);
    chk("R5 release iss_valid", 32'(iss_valid), 1);
    chk("R5 release iss_a", iss_a, 32'h55);
    chk("R6 oldest first", 32'(iss_op), 1);
    @(negedge clk);
    disp_valid = 0;
    for (int k = 1; k < 4; k++) begin
      #1;
      chk("R6 one per cycle", 32'(iss_valid), 1);
      chk("R6 order", 32'(iss_rd), 32'(11 + k));
      chk("R4 operand b", iss_b, 32'h55);
      @(negedge clk);
    end
    #1;
    chk("R7 drained, ignored request absent", 32'(iss_valid), 0);
    chk("R7 ready after drain", 32'(disp_ready), 1);

    rst_n = 1'b0;
    #1;
    chk("R1 reset clears buffer", 32'(iss_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    disp_valid = 1; disp_op = 2; disp_rd = 1; disp_rs1 = 5; disp_rs2 = 7;
    @(negedge clk);
    idle();
    #1;
    chk("R1 registers valid after reset", 32'(iss_valid), 1);
    chk("R1 registers zero after reset", iss_a, 0);
    finish_run();
  end
endmodule